// File: doc/BRIEF.md
# Memory Bit Manipulation Unit

This execution unit carries out one single-bit instruction on a byte that lives in memory. The instruction is set up by a decoder and address stage that sit outside the block. They supply an effective address, an operation code, a bit index source and the current condition flags, and they raise `start` for one cycle. The unit reads the byte through a byte-wide request/ready memory port. It computes the new carry, zero, half-carry and subtract flags, and writes the modified byte back when the operation calls for it. When the operation's cycle budget has run out, it raises `done` for one clock.

The bit index is taken from one of two places: a 3-bit immediate field, or the low nibble of the accumulator. In accumulator mode an index of 8 or more turns the instruction into a timed no-op. Operations that name no flag leave the incoming flags untouched on `flags_out`.

Top module: `membit_unit`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `mem_req` are 0.
- R2: Op codes 0, 1 and 2 (AND, OR and XOR into carry) combine the selected memory bit with C by that logic function and place the result in C. No memory write is issued.
- R3: Op code 3 copies the selected memory bit into C. No memory write is issued.
- R4: Op code 4 writes C into the selected bit and leaves the other seven bits of the byte as they were.
- R5: Op code 5 (test-and-set) sets Z to the inverse of the original bit, writes the byte back with that bit at 1, sets H to 1 and clears N. Its budget is 10 cycles.
- R6: Op code 6 (bit test) sets Z to the inverse of the selected bit, sets H to 1 and clears N. No memory write is issued.
- R7: Op codes 7, 8 and 9 clear, set and toggle the selected bit with one read and one write. `flags_out` equals `flags_in`.
- R8: When `idx_from_acc` is 1, the index is `acc[3:0]` and the immediate is ignored. An index of 8 or more issues no memory access, leaves the flags unchanged and still takes the full budget.
- R9: With zero-wait memory, `done` is first seen N rising edges after the edge that accepts `start`, where N is 8, or 10 for op code 5. `done` is high for exactly one clock. Memory stalls can only delay `done`: it then comes one cycle after the last handshake.
- R10: Each instruction issues at most one read and at most one write, and any write comes after the read. A request holds its direction and address until `mem_ready`.
- R11: The flag bits an operation does not name are passed from `flags_in` to `flags_out` unchanged. The flag vector is bit 0 = C, bit 1 = Z, bit 2 = H, bit 3 = N.
- R12: Op codes 10 to 15 are undefined. They issue no memory access, leave the flags unchanged and take 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction; ignored while busy |
| op | input | 4 | Operation code |
| idx_from_acc | input | 1 | 1: index from accumulator low nibble; 0: from immediate |
| imm_idx | input | 3 | Immediate bit index |
| acc | input | 8 | Accumulator value |
| addr | input | 8 | Effective address of the byte |
| flags_in | input | 4 | Current flags {N,H,Z,C} |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Completes the current request |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-clock end-of-instruction pulse |
| flags_out | output | 4 | Resulting flags {N,H,Z,C} |

## Verification
The carry-combine operations are driven with every pairing of a memory bit at 0 or 1 and C at 0 or 1 that matters to each function. This tells AND, OR and XOR apart, and tells all three apart from a plain copy. Read-modify-write operations start from bytes with mixed neighbouring bits, so that a wrong mask or a wrong polarity shows up in the written byte. Test-and-set is run twice on the same byte, first on a clear bit and then on a set one, to separate capturing the old bit from capturing the new one. Accumulator indexes with a set upper nibble, with bit 3 set, and with stalled memory show whether the index is decoded correctly, whether out-of-range indexes stay silent, and whether the cycle budget is held in both directions.

// File: rtl/membit_pkg.sv
package membit_pkg;

    typedef enum logic [3:0] {
        OP_ANDC = 4'd0,
        OP_ORC  = 4'd1,
        OP_XORC = 4'd2,
        OP_LDC  = 4'd3,
        OP_STC  = 4'd4,
        OP_TSET = 4'd5,
        OP_BIT  = 4'd6,
        OP_RES  = 4'd7,
        OP_SET  = 4'd8,
        OP_CHG  = 4'd9
    } bitop_e;

    typedef struct packed {
        logic n;
        logic h;
        logic z;
        logic c;
    } flags_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_HOLD  = 2'd3
    } state_e;

    function automatic logic op_known(input logic [3:0] code);
        return code <= 4'd9;
    endfunction

endpackage

// File: rtl/membit_index.sv
module membit_index #(
    parameter int DW = 8,
    localparam int BW = $clog2(DW)
) (
    input  logic          from_acc,
    input  logic [BW-1:0] imm,
    input  logic [BW:0]   acc_low,
    output logic [BW-1:0] idx,
    output logic          in_range
);
    always_comb begin
        if (from_acc) begin
            idx      = acc_low[BW-1:0];
            in_range = ~acc_low[BW];
        end else begin
            idx      = imm;
            in_range = 1'b1;
        end
    end
endmodule

// File: rtl/membit_alu.sv
module membit_alu
    import membit_pkg::*;
#(
    parameter int DW = 8,
    localparam int BW = $clog2(DW)
) (
    input  bitop_e        op,
    input  logic [DW-1:0] rd,
    input  logic [BW-1:0] idx,
    input  flags_t        fin,
    output logic [DW-1:0] wr,
    output flags_t        fout,
    output logic          wen
);
    logic [DW-1:0] mask;
    logic          sel;

    always_comb begin
        mask = DW'(1) << idx;
        sel  = |(rd & mask);
        wr   = rd;
        fout = fin;
        wen  = 1'b0;
        case (op)
            OP_ANDC: fout.c = sel & fin.c;
            OP_ORC:  fout.c = sel | fin.c;
            OP_XORC: fout.c = sel ^ fin.c;
            OP_LDC:  fout.c = sel;
            OP_STC: begin
                wr  = fin.c ? (rd | mask) : (rd & ~mask);
                wen = 1'b1;
            end
            OP_TSET: begin
                fout.z = ~sel;
                fout.h = 1'b1;
                fout.n = 1'b0;
                wr     = rd | mask;
                wen    = 1'b1;
            end
            OP_BIT: begin
                fout.z = ~sel;
                fout.h = 1'b1;
                fout.n = 1'b0;
            end
            OP_RES: begin wr = rd & ~mask; wen = 1'b1; end
            OP_SET: begin wr = rd | mask;  wen = 1'b1; end
            OP_CHG: begin wr = rd ^ mask;  wen = 1'b1; end
            default: ;
        endcase
    end

    // R7: plain bit edits must leave every flag alone
    always_comb begin
        if (op == OP_RES || op == OP_SET || op == OP_CHG)
            a_r7_flags_kept: assert (fout == fin);
    end
endmodule

// File: rtl/membit_unit.sv
module membit_unit
    import membit_pkg::*;
#(
    parameter int DW       = 8,
    parameter int AW       = 8,
    parameter int CYC_STD  = 8,
    parameter int CYC_TSET = 10,
    localparam int BW      = $clog2(DW),
    localparam int CYC_MAX = (CYC_TSET > CYC_STD) ? CYC_TSET : CYC_STD,
    localparam int CW      = $clog2(CYC_MAX + 1) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    op,
    input  logic          idx_from_acc,
    input  logic [BW-1:0] imm_idx,
    input  logic [DW-1:0] acc,
    input  logic [AW-1:0] addr,
    input  logic [3:0]    flags_in,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          busy,
    output logic          done,
    output logic [3:0]    flags_out
);
    typedef struct packed {
        state_e        st;
        logic [CW-1:0] cnt;
        bitop_e        op;
        logic [BW-1:0] idx;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        flags_t        fl;
    } regs_t;

    regs_t r_q, r_d;

    logic [BW-1:0] idx_now;
    logic          in_range_now;
    logic [DW-1:0] alu_wr;
    flags_t        alu_fl;
    logic          alu_wen;
    logic [CW-1:0] budget_q;
    logic [CW-1:0] cnt_inc;

    membit_index #(.DW(DW)) u_index (
        .from_acc (idx_from_acc),
        .imm      (imm_idx),
        .acc_low  (acc[BW:0]),
        .idx      (idx_now),
        .in_range (in_range_now)
    );

    membit_alu #(.DW(DW)) u_alu (
        .op   (r_q.op),
        .rd   (mem_rdata),
        .idx  (r_q.idx),
        .fin  (r_q.fl),
        .wr   (alu_wr),
        .fout (alu_fl),
        .wen  (alu_wen)
    );

    always_comb begin
        budget_q = (r_q.op == OP_TSET) ? CW'(CYC_TSET) : CW'(CYC_STD);
        cnt_inc  = (r_q.cnt == {CW{1'b1}}) ? r_q.cnt : r_q.cnt + 1'b1;
        r_d      = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = (in_range_now && op_known(op)) ? ST_READ : ST_HOLD;
                    r_d.cnt  = CW'(1);
                    r_d.op   = bitop_e'(op);
                    r_d.idx  = idx_now;
                    r_d.addr = addr;
                    r_d.fl   = flags_t'(flags_in);
                end
            end
            ST_READ: begin
                r_d.cnt = cnt_inc;
                if (mem_ready) begin
                    r_d.fl    = alu_fl;
                    r_d.wdata = alu_wr;
                    r_d.st    = alu_wen ? ST_WRITE : ST_HOLD;
                end
            end
            ST_WRITE: begin
                r_d.cnt = cnt_inc;
                if (mem_ready) r_d.st = ST_HOLD;
            end
            ST_HOLD: begin
                if (r_q.cnt >= budget_q) r_d.st = ST_IDLE;
                else                     r_d.cnt = cnt_inc;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = (r_q.st == ST_HOLD) && (r_q.cnt >= budget_q);
    assign mem_req   = (r_q.st == ST_READ) || (r_q.st == ST_WRITE);
    assign mem_we    = (r_q.st == ST_WRITE);
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;
    assign flags_out = r_q.fl;

    // R9: the end pulse lasts one clock
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a write is only started right after a completed read
    a_r10_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !$past(mem_req && mem_we))
            |-> $past(mem_req && !mem_we && mem_ready));

    // R10: a stalled request keeps its direction and address
    a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    // R8: out-of-range accumulator index touches no memory
    a_r8_no_access_high_idx: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && idx_from_acc && acc[BW]) |=> !mem_req);

    // R1: no memory traffic outside an instruction
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done));
endmodule

// File: tb/membit_unit_bench.sv
module membit_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] op = '0;
    logic       idx_from_acc = 1'b0;
    logic [2:0] imm_idx = '0;
    logic [7:0] acc = '0;
    logic [7:0] addr = '0;
    logic [3:0] flags_in = '0;
    logic       mem_req, mem_we, busy, done;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_ready;
    logic [3:0] flags_out;

    logic [7:0] mem [0:255];
    int wait_n = 0;
    int wcnt = 0;
    int nrd = 0;
    int nwr = 0;
    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [3:0] fres;

    always #(CLK_PERIOD/2) clk = ~clk;

    membit_unit u_membit_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .idx_from_acc(idx_from_acc), .imm_idx(imm_idx), .acc(acc),
        .addr(addr), .flags_in(flags_in), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy),
        .done(done), .flags_out(flags_out)
    );

    assign mem_rdata = mem[mem_addr];
    assign mem_ready = mem_req && (wcnt >= wait_n);

    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            wcnt <= 0;
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                nwr = nwr + 1;
            end else begin
                nrd = nrd + 1;
            end
        end else if (mem_req) begin
            wcnt <= wcnt + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Runs one instruction; cyc = edges from accept to first done
    task automatic run_op(input logic [3:0] o, input logic fa, input logic [2:0] im,
                          input logic [7:0] ac, input logic [7:0] ad, input logic [3:0] fi);
        int n;
        @(negedge clk);
        nrd = 0; nwr = 0;
        op = o; idx_from_acc = fa; imm_idx = im; acc = ac; addr = ad; flags_in = fi;
        start = 1'b1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 100) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL R9: done never came, actual=%0d expected<100", n);
        end
        cyc  = n;
        fres = flags_out;
        @(negedge clk);
        chk("R9 done one clock", done, 0);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 mem_req", mem_req, 0);
    endtask

    task automatic t_carry_combine();
        mem[8'h20] = 8'hA5;
        run_op(4'd0, 0, 3'd0, 0, 8'h20, 4'b0001); chk("R2 AND 1&1", fres, 4'b0001);
        run_op(4'd0, 0, 3'd1, 0, 8'h20, 4'b0001); chk("R2 AND 0&1", fres, 4'b0000);
        run_op(4'd1, 0, 3'd1, 0, 8'h20, 4'b0000); chk("R2 OR 0|0", fres, 4'b0000);
        run_op(4'd1, 0, 3'd2, 0, 8'h20, 4'b0000); chk("R2 OR 1|0", fres, 4'b0001);
        run_op(4'd2, 0, 3'd0, 0, 8'h20, 4'b0001); chk("R2 XOR 1^1", fres, 4'b0000);
        chk("R2 no write", nwr, 0);
        chk("R2 mem kept", mem[8'h20], 8'hA5);
        chk("R9 std budget", cyc, 8);
    endtask

    task automatic t_load_store();
        mem[8'h21] = 8'h80;
        run_op(4'd3, 0, 3'd7, 0, 8'h21, 4'b0000); chk("R3 load 1", fres, 4'b0001);
        run_op(4'd3, 0, 3'd6, 0, 8'h21, 4'b0001); chk("R3 load 0", fres, 4'b0000);
        chk("R3 no write", nwr, 0);
        mem[8'h22] = 8'h00;
        run_op(4'd4, 0, 3'd3, 0, 8'h22, 4'b0001);
        chk("R4 store 1", mem[8'h22], 8'h08);
        chk("R4 flags", fres, 4'b0001);
        mem[8'h23] = 8'hFF;
        run_op(4'd4, 0, 3'd7, 0, 8'h23, 4'b0000);
        chk("R4 store 0", mem[8'h23], 8'h7F);
    endtask

    task automatic t_test_and_set();
        mem[8'h24] = 8'h00;
        run_op(4'd5, 0, 3'd2, 0, 8'h24, 4'b1001);
        chk("R5 flags first", fres, 4'b0111);
        chk("R5 byte first", mem[8'h24], 8'h04);
        chk("R5 R9 budget ten", cyc, 10);
        run_op(4'd5, 0, 3'd2, 0, 8'h24, 4'b0000);
        chk("R5 flags second", fres, 4'b0100);
        chk("R5 byte second", mem[8'h24], 8'h04);
    endtask

    task automatic t_bit_test();
        mem[8'h25] = 8'h10;
        run_op(4'd6, 0, 3'd4, 0, 8'h25, 4'b1011);
        chk("R6 R11 bit set", fres, 4'b0101);
        run_op(4'd6, 0, 3'd5, 0, 8'h25, 4'b0000);
        chk("R6 bit clear", fres, 4'b0110);
        chk("R6 no write", nwr, 0);
        chk("R6 byte kept", mem[8'h25], 8'h10);
    endtask

    task automatic t_edits();
        mem[8'h26] = 8'hF0;
        run_op(4'd7, 0, 3'd7, 0, 8'h26, 4'b1010); chk("R7 res", mem[8'h26], 8'h70);
        chk("R7 R11 res flags", fres, 4'b1010);
        run_op(4'd8, 0, 3'd0, 0, 8'h26, 4'b0101); chk("R7 set", mem[8'h26], 8'h71);
        chk("R7 set flags", fres, 4'b0101);
        run_op(4'd9, 0, 3'd4, 0, 8'h26, 4'b1010); chk("R7 chg off", mem[8'h26], 8'h61);
        run_op(4'd9, 0, 3'd1, 0, 8'h26, 4'b1010); chk("R7 chg on", mem[8'h26], 8'h63);
        chk("R7 R10 one read", nrd, 1);
        chk("R7 R10 one write", nwr, 1);
    endtask

    task automatic t_acc_index();
        mem[8'h27] = 8'h00;
        run_op(4'd8, 1, 3'd5, 8'h13, 8'h27, 4'b0000);
        chk("R8 acc index", mem[8'h27], 8'h08);
        run_op(4'd8, 1, 3'd0, 8'h09, 8'h27, 4'b1111);
        chk("R8 high idx byte", mem[8'h27], 8'h08);
        chk("R8 high idx flags", fres, 4'b1111);
        chk("R8 high idx reads", nrd + nwr, 0);
        chk("R8 high idx cycles", cyc, 8);
        run_op(4'd5, 1, 3'd0, 8'h0F, 8'h27, 4'b0000);
        chk("R8 tset high cycles", cyc, 10);
        chk("R8 tset high access", nrd + nwr, 0);
    endtask

    task automatic t_undefined();
        mem[8'h29] = 8'h5A;
        run_op(4'hF, 0, 3'd1, 0, 8'h29, 4'b0110);
        chk("R12 no access", nrd + nwr, 0);
        chk("R12 flags", fres, 4'b0110);
        chk("R12 cycles", cyc, 8);
        chk("R12 byte kept", mem[8'h29], 8'h5A);
    endtask

    task automatic t_stalls();
        mem[8'h28] = 8'h00;
        wait_n = 2;
        run_op(4'd9, 0, 3'd0, 0, 8'h28, 4'b0000);
        chk("R9 short stall cycles", cyc, 8);
        chk("R10 stall byte", mem[8'h28], 8'h01);
        chk("R10 stall reads", nrd, 1);
        chk("R10 stall writes", nwr, 1);
        wait_n = 4;
        run_op(4'd9, 0, 3'd0, 0, 8'h28, 4'b0000);
        chk("R9 long stall cycles", cyc, 11);
        chk("R10 long stall byte", mem[8'h28], 8'h00);
        run_op(4'd6, 0, 3'd0, 0, 8'h28, 4'b0000);
        chk("R9 stalled read cycles", cyc, 8);
        wait_n = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_carry_combine();
        t_load_store();
        t_test_and_set();
        t_bit_test();
        t_edits();
        t_acc_index();
        t_undefined();
        t_stalls();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule